// File: doc/BRIEF.md
# Dual-Address I2C Byte Memory with Block Write Protection

This block is an I2C target that sits on one two-wire bus under two device addresses. The first address reaches a byte-wide memory array of 2**ADDR_W locations. The intended sizes are ADDR_W = 13 or 15, which give 8,192 or 32,768 bytes. A write to the array sends a high address byte, then a low address byte, then any number of data bytes. A read that follows with no address phase, or after a repeated start, returns data from the internal pointer.

The second address reaches a small register bank of 2**RIDX_W bytes. The bank is written and read through a one-byte register index that advances by itself. Bits [3:2] of the register at index WP_IDX (0x0B) set how much of the array is locked against writes. A data byte aimed at a locked location is answered with a NACK and is not stored. Reads are never blocked. Traffic to the register bank does not move the array pointer, so a host can poll the bank between array reads without losing its place.

SCL and SDA arrive as sampled levels and pass through two-flop synchronizers. `sda_oe` high means the block pulls SDA low. Clock stretching is not used.

Top module: `i2c_wp_mem`

## Requirements
- R1: After reset, `sda_oe` is 0, the array pointer is 0, every register is 0, and so no address is write-protected.
- R2: A device byte whose upper seven bits equal MEM_ID or REG_ID is acknowledged. Any other device byte is not acknowledged, and `sda_oe` stays 0 until the next start.
- R3: A write to MEM_ID takes a high address byte and then a low address byte. Together they form a 16-bit address, of which only the low ADDR_W bits are kept. Each following data byte is stored and acknowledged when its location is unprotected.
- R4: The array pointer advances by one after every data byte, read or written, and steps from 2**ADDR_W-1 back to 0.
- R5: A read from MEM_ID, whether after a repeated start or on its own, returns the byte at the pointer first. The read goes on while the host acknowledges and ends on a host NACK.
- R6: On REG_ID, the first byte written is the register index, of which the low RIDX_W bits are kept. Later bytes write registers, and reads return registers, from that index upward, wrapping modulo 2**RIDX_W.
- R7: A transfer addressed to REG_ID leaves the array pointer unchanged.
- R8: The protect field is bits [3:2] of register WP_IDX. 00 protects nothing. 01 protects addresses below 2**ADDR_W/4. 10 protects addresses below 2**ADDR_W/2. 11 protects every address.
- R9: A data byte written to a protected address gets a NACK, leaves the array unchanged and still advances the pointer. Later unprotected bytes of the same burst are acknowledged and stored.
- R10: Reads return array contents whatever the protect field holds.
- R11: The block changes `sda_oe` to 1 only while the synchronized SCL is low, and it holds `sda_oe` at 0 while idle. A stop returns it to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Sampled level of the bus clock line |
| sda_i | input | 1 | Sampled level of the bus data line |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge or a 0 data bit) |

## Verification
The array is filled and read back in bursts that cross the top address, so wrap and auto-increment are seen in both directions. Random reads, current-address reads and writes that stop after the address phase separate the pointer-load paths from the pointer-advance paths. A register-bank burst whose index wraps past the last register, followed by an array read, tells a correctly kept pointer from a disturbed one. Every protect setting is swept with a full-array write and readback, comparing the acknowledge of each byte and each stored value against an arithmetic protect model. This shows the quarter and half boundaries exactly and shows that reads pass while writes are locked.

// File: rtl/i2c_wp_mem.sv
module i2c_wp_mem #(
  parameter int          ADDR_W = 10,
  parameter logic [6:0]  MEM_ID = 7'h50,
  parameter logic [6:0]  REG_ID = 7'h68,
  parameter int          RIDX_W = 4,
  parameter int          WP_IDX = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int NREG  = 1 << RIDX_W;

  typedef enum logic [2:0] {P_IDLE, P_DEV, P_AH, P_AL, P_RI, P_WR, P_RD} phase_t;

  logic [1:0] scl_q, sda_q;
  logic       scl_d, sda_d;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 2'b11; sda_q <= 2'b11; scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[0], scl_i};
      sda_q <= {sda_q[0], sda_i};
      scl_d <= scl_q[1];
      sda_d <= sda_q[1];
    end
  end

  wire scl_s    = scl_q[1];
  wire sda_s    = sda_q[1];
  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;
  wire start_c  = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_c   = scl_s & scl_d & ~sda_d & sda_s;

  phase_t            phase, nxt;
  logic [3:0]        cnt;
  logic              in_ack, ack_go, is_reg, mack;
  logic [7:0]        sr, tx, ah;
  logic [ADDR_W-1:0] ptr;
  logic [RIDX_W-1:0] ridx;
  logic [7:0]        regs [NREG];
  logic [7:0]        mem  [DEPTH];

  wire [7:0] byte_in = {sr[6:0], sda_s};
  wire [1:0] wp      = regs[WP_IDX][3:2];

  logic mem_prot;
  always_comb begin
    case (wp)
      2'b00:   mem_prot = 1'b0;
      2'b01:   mem_prot = (ptr[ADDR_W-1:ADDR_W-2] == 2'b00);
      2'b10:   mem_prot = ~ptr[ADDR_W-1];
      default: mem_prot = 1'b1;
    endcase
  end

  wire byte_done = scl_rise & ~in_ack & (cnt == 4'd7) & (phase != P_RD) & (phase != P_IDLE);
  wire we        = byte_done & (phase == P_WR) & ~is_reg & ~mem_prot;
  wire [7:0] rd_byte = is_reg ? regs[ridx] : mem[ptr];

  always_ff @(posedge clk) begin
    if (we) mem[ptr] <= byte_in;
  end

  wire dev_mem = (byte_in[7:1] == MEM_ID);
  wire dev_reg = (byte_in[7:1] == REG_ID);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= P_IDLE; nxt <= P_IDLE;
      cnt <= '0; in_ack <= 1'b0; ack_go <= 1'b0; is_reg <= 1'b0; mack <= 1'b1;
      sr <= '0; tx <= '0; ah <= '0; ptr <= '0; ridx <= '0; sda_oe <= 1'b0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (start_c) begin
      phase <= P_DEV; cnt <= '0; in_ack <= 1'b0; sda_oe <= 1'b0;
    end else if (stop_c) begin
      phase <= P_IDLE; in_ack <= 1'b0; sda_oe <= 1'b0;
    end else if (phase == P_RD) begin
      if (scl_rise) begin
        if (in_ack) mack <= sda_s;
        else        cnt  <= cnt + 4'd1;
      end
      if (scl_fall) begin
        if (in_ack) begin
          in_ack <= 1'b0;
          cnt    <= '0;
          if (!mack) begin
            tx     <= rd_byte;
            sda_oe <= ~rd_byte[7];
            if (is_reg) ridx <= ridx + 1'b1;
            else        ptr  <= ptr + 1'b1;
          end else begin
            phase  <= P_IDLE;
            sda_oe <= 1'b0;
          end
        end else if (cnt == 4'd8) begin
          in_ack <= 1'b1;
          sda_oe <= 1'b0;
        end else if (cnt != 4'd0) begin
          tx     <= {tx[6:0], 1'b0};
          sda_oe <= ~tx[6];
        end
      end
    end else if (phase != P_IDLE) begin
      if (scl_rise && !in_ack) begin
        sr  <= byte_in;
        cnt <= cnt + 4'd1;
        if (cnt == 4'd7) begin
          ack_go <= 1'b1;
          case (phase)
            P_DEV: begin
              if (dev_mem || dev_reg) begin
                is_reg <= dev_reg;
                nxt    <= byte_in[0] ? P_RD : (dev_reg ? P_RI : P_AH);
              end else begin
                ack_go <= 1'b0;
                nxt    <= P_IDLE;
              end
            end
            P_AH: begin ah <= byte_in; nxt <= P_AL; end
            P_AL: begin ptr <= ADDR_W'({ah, byte_in}); nxt <= P_WR; end
            P_RI: begin ridx <= RIDX_W'(byte_in); nxt <= P_WR; end
            default: begin
              nxt <= P_WR;
              if (is_reg) begin
                regs[ridx] <= byte_in;
                ridx       <= ridx + 1'b1;
              end else begin
                ack_go <= ~mem_prot;
                ptr    <= ptr + 1'b1;
              end
            end
          endcase
        end
      end
      if (scl_fall) begin
        if (in_ack) begin
          in_ack <= 1'b0;
          cnt    <= '0;
          phase  <= nxt;
          if (nxt == P_RD) begin
            tx     <= rd_byte;
            sda_oe <= ~rd_byte[7];
            if (is_reg) ridx <= ridx + 1'b1;
            else        ptr  <= ptr + 1'b1;
          end else begin
            sda_oe <= 1'b0;
          end
        end else if (cnt == 4'd8) begin
          in_ack <= 1'b1;
          sda_oe <= ack_go;
        end
      end
    end
  end

endmodule

// File: rtl/i2c_wp_mem_chk.sv
module i2c_wp_mem_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              sda_oe,
  input logic              idle,
  input logic              in_ack,
  input logic              wr_mem,
  input logic              reg_busy,
  input logic [1:0]        wp,
  input logic              we,
  input logic [ADDR_W-1:0] ptr
);
  localparam int DEPTH = 1 << ADDR_W;

  logic locked;
  always_comb begin
    locked = 1'b0;
    if (wp == 2'b11) locked = 1'b1;
    else if (wp == 2'b10 && int'(ptr) < DEPTH / 2) locked = 1'b1;
    else if (wp == 2'b01 && int'(ptr) < DEPTH / 4) locked = 1'b1;
  end

  a_r11_pull_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_s));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !sda_oe);

  a_r9_no_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> !locked);

  a_r8_full_lock_nack: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ack && wr_mem && wp == 2'b11) |-> !sda_oe);

  a_r7_ptr_kept: assert property (@(posedge clk) disable iff (!rst_n)
    reg_busy |=> $stable(ptr));
endmodule

bind i2c_wp_mem i2c_wp_mem_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .idle(phase == P_IDLE), .in_ack(in_ack),
  .wr_mem(phase == P_WR && !is_reg), .reg_busy(is_reg && phase != P_IDLE),
  .wp(wp), .we(we), .ptr(ptr)
);

// File: tb/sim_i2c_wp_mem.sv
module sim_i2c_wp_mem;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;
  localparam logic [7:0] MW = 8'hA0, MR = 8'hA1, RW = 8'hD0, RR = 8'hD1;
  localparam int Q = 3;

  logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe;
  wire  sda_bus = m_sda & ~sda_oe;
  always #2 clk = ~clk;

  i2c_wp_mem #(.ADDR_W(AW), .MEM_ID(7'h50), .REG_ID(7'h68), .RIDX_W(4), .WP_IDX(11)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe));

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] model [DEPTH];
  bit watch = 1'b0, drove = 1'b0;
  always @(negedge clk) if (watch && sda_oe) drove = 1'b1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic clk_bit(input logic d, output logic s);
    m_sda = d; w(Q); m_scl = 1'b1; w(Q); s = sda_bus; w(Q); m_scl = 1'b0; w(Q);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; w(Q); m_scl = 1'b1; w(Q); m_sda = 1'b0; w(Q); m_scl = 1'b0; w(Q);
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; w(Q); m_scl = 1'b1; w(Q); m_sda = 1'b1; w(Q);
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = !s;
  endtask

  task automatic rbyte(input bit last, output logic [7:0] b);
    logic s;
    b = '0;
    for (int i = 0; i < 8; i++) begin clk_bit(1'b1, s); b = {b[6:0], s}; end
    clk_bit(last, s);
  endtask

  function automatic bit locked(input int wp, input int a);
    case (wp)
      1: return a < DEPTH / 4;
      2: return a < DEPTH / 2;
      3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo, input string req);
    bit a;
    i2c_start(); wbyte(MW, a); chk(a, req, a, 1);
    wbyte(hi, a); chk(a, req, a, 1);
    wbyte(lo, a); chk(a, req, a, 1);
  endtask

  task automatic read_run(input int first, input int n, input string req);
    bit a; logic [7:0] b;
    i2c_start(); wbyte(MR, a); chk(a, "R2 read id ack", a, 1);
    for (int i = 0; i < n; i++) begin
      rbyte(i == n - 1, b);
      chk(b == model[(first + i) % DEPTH], req, b, model[(first + i) % DEPTH]);
    end
    i2c_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit a; logic [7:0] b;
    w(5); rst_n = 1'b1; w(5);
    chk(sda_oe == 1'b0, "R1 reset release", sda_oe, 0);

    // R2: foreign addresses, write and read form
    watch = 1'b1;
    i2c_start(); wbyte(8'h46, a); chk(!a, "R2 foreign write nack", a, 0);
    wbyte(8'h00, a); i2c_stop();
    i2c_start(); wbyte(8'hA3, a); chk(!a, "R2 foreign read nack", a, 0);
    i2c_stop();
    watch = 1'b0;
    chk(!drove, "R2 foreign never driven", drove, 0);

    // R1 R3 R8: full fill with high byte junk and low byte upper bits set
    set_addr(8'hA1, 8'hC0, "R3 address ack");
    for (int i = 0; i < DEPTH; i++) begin
      model[i] = 8'((i * 37 + 5) & 255);
      wbyte(model[i], a); chk(a, "R1 R8 unprotected after reset", a, 1);
    end
    i2c_stop();

    // R4 R5: random read wrapping past the top
    set_addr(8'h00, 8'h00, "R5 address ack");
    i2c_start(); wbyte(MR, a); chk(a, "R5 rstart read ack", a, 1);
    for (int i = 0; i < DEPTH + 2; i++) begin
      rbyte(i == DEPTH + 1, b);
      chk(b == model[i % DEPTH], "R4 R5 read wrap", b, model[i % DEPTH]);
    end
    i2c_stop();
    read_run(2, 3, "R5 current address read");

    // R4: write burst wrapping at the top
    set_addr(8'h00, 8'(DEPTH - 2), "R4 address ack");
    for (int i = 0; i < 4; i++) begin
      model[(DEPTH - 2 + i) % DEPTH] = 8'(200 + i);
      wbyte(8'(200 + i), a); chk(a, "R4 wrap write ack", a, 1);
    end
    i2c_stop();
    set_addr(8'h00, 8'(DEPTH - 2), "R4 address ack");
    i2c_stop();
    read_run(DEPTH - 2, 4, "R4 wrap readback");

    // R6 R7: register burst wrapping index, pointer parked at 0x20
    set_addr(8'h00, 8'h20, "R7 park ack");
    i2c_stop();
    i2c_start(); wbyte(RW, a); chk(a, "R2 R6 reg id ack", a, 1);
    wbyte(8'hFE, a); chk(a, "R6 index ack", a, 1);
    wbyte(8'h11, a); wbyte(8'h22, a); wbyte(8'h33, a); chk(a, "R6 reg data ack", a, 1);
    i2c_stop();
    i2c_start(); wbyte(RW, a); wbyte(8'h0E, a);
    i2c_start(); wbyte(RR, a); chk(a, "R6 reg read ack", a, 1);
    rbyte(1'b0, b); chk(b == 8'h11, "R6 reg 14", b, 8'h11);
    rbyte(1'b0, b); chk(b == 8'h22, "R6 reg 15", b, 8'h22);
    rbyte(1'b1, b); chk(b == 8'h33, "R6 reg index wrap", b, 8'h33);
    i2c_stop();
    read_run(8'h20, 2, "R7 pointer kept over reg access");

    // R8 R9 R10: sweep every protect setting over the full array
    for (int wp = 0; wp < 4; wp++) begin
      i2c_start(); wbyte(RW, a); wbyte(8'h0B, a);
      wbyte(8'(wp << 2), a); chk(a, "R8 protect reg write ack", a, 1);
      i2c_stop();
      set_addr(8'h00, 8'h00, "R9 address ack");
      for (int i = 0; i < DEPTH; i++) begin
        logic [7:0] v;
        v = 8'((i * 13 + wp * 71 + 1) & 255);
        wbyte(v, a);
        chk(a == !locked(wp, i), "R8 R9 ack per protect range", a, !locked(wp, i));
        if (!locked(wp, i)) model[i] = v;
      end
      i2c_stop();
      set_addr(8'h00, 8'h00, "R10 address ack");
      i2c_stop();
      read_run(0, DEPTH, "R9 R10 readback under protection");
      i2c_start(); wbyte(RW, a); wbyte(8'h0B, a);
      i2c_start(); wbyte(RR, a); rbyte(1'b1, b);
      chk(b == 8'(wp << 2), "R8 protect reg readback", b, wp << 2);
      i2c_stop();
    end

    // R11: idle bus after stop leaves SDA released
    w(20);
    chk(sda_oe == 1'b0, "R11 idle release", sda_oe, 0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule